// File: doc/BRIEF.md
# Triggered Hold and Event Cell Write Controller

This block runs the write side of a small analog event store while an acquisition window is open. Every input channel carries a discriminator output. The block merges them into one trigger. A trigger edge starts a programmable wait. When the wait ends, a one-cycle hold strobe freezes the shaped signal near its peak into the cell that is currently selected. The cell selection then moves on to the next cell, and the count of stored events goes up by one.

The acquisition controller opens a window with a start pulse and may close it early with a stop pulse. When every cell is in use, or when the window is closed, the block raises a saturation flag. The acquisition system uses that flag to halt triggering and begin digitization. The number of filled cells stays on a port for the conversion stage, which converts each filled cell twice. Analog switches and the converter are outside this block. Hold and cell selection leave it as plain digital signals.

Top module: `evt_hold_ctrl`

## Requirements
- R1: After reset the hold strobe is low, the event count is 0, the saturation flag is low, the cell select has only bit 0 set, and no acquisition is active.
- R2: A trigger is a 0-to-1 change of the OR of all `trig_ch` bits, as seen between two consecutive clock edges. It is accepted only while acquisition is active and no hold is pending. A level held high gives only one trigger. Triggers with no acquisition active have no effect.
- R3: For a trigger accepted in cycle T, with `hold_dly` = D sampled in cycle T, `hold_strobe` is high for exactly one cycle, and that cycle is T+D+2.
- R4: A trigger edge that arrives while a hold is pending (waiting or strobing) is ignored. It produces no extra strobe and no extra count.
- R5: `cell_sel` is one-hot. Bit k is set while the write pointer equals k. The pointer advances by one in the cycle after the strobe. Once all cells are used, no bit is set.
- R6: `evt_count` equals the number of hold strobes completed since the last start. It updates in the cycle after each strobe.
- R7: In the cycle after the strobe that fills the last cell, `chip_sat` goes to 1 and stays there. After that, no trigger produces a strobe until the next start.
- R8: `acq_stop` while the block is waiting for a trigger or waiting out a delay closes the window. `chip_sat` is 1 in the next cycle, any pending hold is dropped without a strobe, and the count does not change.
- R9: `acq_stop` in the same cycle as a hold strobe still counts that event. `chip_sat` is 1 in the next cycle.
- R10: `acq_start` clears the pointer, the count and `chip_sat`, cancels any pending hold, and re-opens acquisition. It takes priority over a trigger or stop in the same cycle, and a trigger edge in that same cycle is ignored.
- R11: The delay range is exact at both ends: D = 0 gives the strobe 2 cycles after the trigger cycle, and D = 255 gives it 257 cycles after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_start | input | 1 | One-cycle pulse that opens acquisition and clears the store bookkeeping |
| acq_stop | input | 1 | One-cycle pulse that closes acquisition |
| trig_ch | input | 64 | Per-channel discriminator outputs |
| hold_dly | input | 8 | Trigger-to-hold wait in clock cycles |
| hold_strobe | output | 1 | One-cycle sample strobe for the selected cell |
| cell_sel | output | 15 | One-hot write cell select |
| evt_count | output | 4 | Number of filled cells, for the conversion stage |
| chip_sat | output | 1 | Store full or acquisition closed |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes each one on purpose. In the first pair, a stop pulse arrives in the very cycle the hold strobe is high. The bench waits for the strobe, drives the stop in that cycle, and expects the event to be counted and the flag to rise one cycle later. In the second pair, a start pulse coincides with a fresh trigger edge. The bench expects the trigger to be dropped, with a zero count and no strobe afterwards. Random stimulus also lets stop and start collide with pending delays, and a cycle-level reference model judges every output on every cycle.

// File: rtl/hold_ctl_pkg.sv
package hold_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARMED,
        PH_WAIT,
        PH_HOLD,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic clear;
        logic commit;
        logic stop;
    } book_cmd_t;

    function automatic logic phase_live(phase_t p);
        return (p == PH_ARMED) || (p == PH_WAIT) || (p == PH_HOLD);
    endfunction

endpackage

// File: rtl/trig_front.sv
module trig_front #(
    parameter int N_CH = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] trig_ch,
    output logic            trig_edge
);
    logic [N_CH:0] chain;
    logic          any_now;
    logic          any_prev;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < N_CH; i++) begin : g_or
        assign chain[i+1] = chain[i] | trig_ch[i];
    end
    assign any_now = chain[N_CH];

    always_ff @(posedge clk) begin
        if (rst) any_prev <= 1'b0;
        else     any_prev <= any_now;
    end

    assign trig_edge = any_now & ~any_prev;

    // R2: an edge cannot be reported twice in a row
    a_r2_single_edge: assert property (@(posedge clk) disable iff (rst)
        trig_edge |=> !trig_edge);
endmodule

// File: rtl/dly_counter.sv
module dly_counter #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             en,
    output logic             zero
);
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                        cnt <= '0;
        else if (load)                  cnt <= load_val;
        else if (en && cnt != '0)       cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R3: a freshly loaded nonzero value is not reported as expired
    a_r3_load_nonzero: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !zero);
endmodule

// File: rtl/cell_book.sv
module cell_book
    import hold_ctl_pkg::*;
#(
    parameter int N_CELLS = 15,
    parameter int CNT_W   = $clog2(N_CELLS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  book_cmd_t          cmd,
    output logic [CNT_W-1:0]   count,
    output logic [N_CELLS-1:0] sel,
    output logic               sat,
    output logic               last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_CELLS - 1);

    assign last = (count == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            count <= '0;
            sat   <= 1'b0;
        end else begin
            if (cmd.commit && count != CNT_W'(N_CELLS))
                count <= count + 1'b1;
            if (cmd.stop || (cmd.commit && last))
                sat <= 1'b1;
        end
    end

    for (genvar k = 0; k < N_CELLS; k++) begin : g_sel
        assign sel[k] = (count == CNT_W'(k));
    end

    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        (cmd.commit && !cmd.clear) |=> count == CNT_W'($past(count) + 1'b1));

    a_r7_sat_sticky: assert property (@(posedge clk) disable iff (rst)
        (sat && !cmd.clear) |=> sat);

    a_r7_full_implies_sat: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(N_CELLS)) |-> sat);
endmodule

// File: rtl/evt_hold_ctrl.sv
module evt_hold_ctrl
    import hold_ctl_pkg::*;
#(
    parameter int N_CH    = 64,
    parameter int N_CELLS = 15,
    parameter int DLY_W   = 8,
    localparam int CNT_W  = $clog2(N_CELLS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acq_start,
    input  logic               acq_stop,
    input  logic [N_CH-1:0]    trig_ch,
    input  logic [DLY_W-1:0]   hold_dly,
    output logic               hold_strobe,
    output logic [N_CELLS-1:0] cell_sel,
    output logic [CNT_W-1:0]   evt_count,
    output logic               chip_sat
);
    phase_t    ph, ph_nxt;
    logic      trig_edge;
    logic      dly_load, dly_en, dly_zero;
    logic      book_last;
    book_cmd_t cmd;

    trig_front #(.N_CH(N_CH)) u_front (
        .clk(clk), .rst(rst), .trig_ch(trig_ch), .trig_edge(trig_edge)
    );

    dly_counter #(.DLY_W(DLY_W)) u_dly (
        .clk(clk), .rst(rst), .load(dly_load), .load_val(hold_dly),
        .en(dly_en), .zero(dly_zero)
    );

    cell_book #(.N_CELLS(N_CELLS), .CNT_W(CNT_W)) u_book (
        .clk(clk), .rst(rst), .cmd(cmd), .count(evt_count),
        .sel(cell_sel), .sat(chip_sat), .last(book_last)
    );

    always_comb begin
        ph_nxt   = ph;
        dly_load = 1'b0;
        dly_en   = 1'b0;
        cmd      = '0;
        if (acq_start) begin
            ph_nxt    = PH_ARMED;
            cmd.clear = 1'b1;
        end else begin
            case (ph)
                PH_ARMED: begin
                    if (acq_stop) begin
                        ph_nxt   = PH_DONE;
                        cmd.stop = 1'b1;
                    end else if (trig_edge) begin
                        ph_nxt   = PH_WAIT;
                        dly_load = 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (acq_stop) begin
                        ph_nxt   = PH_DONE;
                        cmd.stop = 1'b1;
                    end else if (dly_zero) begin
                        ph_nxt = PH_HOLD;
                    end else begin
                        dly_en = 1'b1;
                    end
                end
                PH_HOLD: begin
                    cmd.commit = 1'b1;
                    if (acq_stop) begin
                        ph_nxt   = PH_DONE;
                        cmd.stop = 1'b1;
                    end else if (book_last) begin
                        ph_nxt = PH_DONE;
                    end else begin
                        ph_nxt = PH_ARMED;
                    end
                end
                default: ph_nxt = ph;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_IDLE;
        else     ph <= ph_nxt;
    end

    assign hold_strobe = (ph == PH_HOLD);

    a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |=> !hold_strobe);

    a_r3_wait_to_hold: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WAIT && dly_zero && !acq_start && !acq_stop) |=> hold_strobe);

    a_r4_no_reload_busy: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WAIT || ph == PH_HOLD) |-> !dly_load);

    a_r7_no_strobe_saturated: assert property (@(posedge clk) disable iff (rst)
        chip_sat |-> !hold_strobe);

    a_r8_stop_sets_sat: assert property (@(posedge clk) disable iff (rst)
        (acq_stop && !acq_start && phase_live(ph)) |=> chip_sat);

    a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
        acq_start |=> (!chip_sat && evt_count == '0 && !hold_strobe));
endmodule

// File: tb/sim_evt_hold_ctrl.sv
module sim_evt_hold_ctrl;
    localparam int CLK_NS  = 10;
    localparam int N_CH    = 64;
    localparam int N_CELLS = 15;
    localparam int DLY_W   = 8;
    localparam int CNT_W   = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               acq_start = 1'b0;
    logic               acq_stop = 1'b0;
    logic [N_CH-1:0]    trig_ch = '0;
    logic [DLY_W-1:0]   hold_dly = '0;
    logic               hold_strobe;
    logic [N_CELLS-1:0] cell_sel;
    logic [CNT_W-1:0]   evt_count;
    logic               chip_sat;

    int n_chk = 0;
    int n_fail = 0;
    int hold_seen = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    evt_hold_ctrl #(.N_CH(N_CH), .N_CELLS(N_CELLS), .DLY_W(DLY_W)) u0 (
        .clk(clk), .rst(rst), .acq_start(acq_start), .acq_stop(acq_stop),
        .trig_ch(trig_ch), .hold_dly(hold_dly), .hold_strobe(hold_strobe),
        .cell_sel(cell_sel), .evt_count(evt_count), .chip_sat(chip_sat)
    );

    always #(CLK_NS/2) clk = ~clk;

    // reference model of the requirements, advanced at each clock edge
    bit m_act, m_pend, m_hold, m_sat, m_prev;
    int m_cnt, m_rem;

    always @(posedge clk) begin
        bit orn, edg;
        orn = |trig_ch;
        edg = orn && !m_prev;
        if (rst) begin
            m_act = 0; m_pend = 0; m_hold = 0; m_sat = 0; m_prev = 0; m_cnt = 0; m_rem = 0;
        end else begin
            m_prev = orn;
            if (acq_start) begin
                m_act = 1; m_pend = 0; m_hold = 0; m_cnt = 0; m_sat = 0;
            end else if (m_act) begin
                if (m_hold) begin
                    m_hold = 0;
                    m_cnt++;
                    if (acq_stop || m_cnt == N_CELLS) begin m_act = 0; m_sat = 1; end
                end else if (m_pend) begin
                    if (acq_stop) begin m_pend = 0; m_act = 0; m_sat = 1; end
                    else if (m_rem == 0) begin m_pend = 0; m_hold = 1; end
                    else m_rem--;
                end else if (acq_stop) begin
                    m_act = 0; m_sat = 1;
                end else if (edg) begin
                    m_pend = 1; m_rem = int'(hold_dly);
                end
            end
        end
    end

    function automatic int exp_sel(int c);
        return (c < N_CELLS) ? (1 << c) : 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (hold_strobe) hold_seen++;
        if (chk_on && !rst && !done) begin
            check(hold_strobe == m_hold, "R3 strobe timing", int'(hold_strobe), int'(m_hold));
            check(int'(cell_sel) == exp_sel(m_cnt), "R5 cell select", int'(cell_sel), exp_sel(m_cnt));
            check(int'(evt_count) == m_cnt, "R6 event count", int'(evt_count), m_cnt);
            check(chip_sat == m_sat, "R7 saturation", int'(chip_sat), int'(m_sat));
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic pulse_start();
        acq_start = 1'b1; tick(); acq_start = 1'b0;
    endtask

    // one-cycle trigger on channel ch; returns cycles until the strobe is seen
    task automatic fire(input int ch, output int lat);
        lat = 0;
        trig_ch = '0;
        trig_ch[ch] = 1'b1;
        while (lat < 400) begin
            tick();
            lat++;
            if (lat == 1) trig_ch = '0;
            if (hold_strobe) break;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0017));
        tick(3);
        rst = 1'b0;
        chk_on = 1'b1;
        // R1 reset state
        check(hold_strobe == 1'b0 && evt_count == '0 && chip_sat == 1'b0 && cell_sel == 15'd1,
              "R1 reset state", int'({hold_strobe, chip_sat, evt_count}), 0);

        begin
            int base, lat, h0;
            // R2 trigger with no acquisition active
            base = hold_seen;
            trig_ch[7] = 1'b1; tick(); trig_ch = '0; tick(10);
            check(hold_seen == base && evt_count == '0, "R2 idle trigger ignored", hold_seen - base, 0);

            pulse_start();
            hold_dly = 8'd3;
            fire(5, lat);
            check(lat == 5, "R3 latency D=3", lat, 5);
            tick();
            check(evt_count == 4'd1 && cell_sel == 15'd2, "R5 pointer after strobe", int'(cell_sel), 2);

            // R4 second edge during pending delay
            hold_dly = 8'd20;
            h0 = hold_seen;
            trig_ch[1] = 1'b1; tick(); trig_ch = '0; tick(5);
            trig_ch[40] = 1'b1; tick(); trig_ch = '0; tick(40);
            check(hold_seen - h0 == 1, "R4 pending trigger ignored", hold_seen - h0, 1);
            check(evt_count == 4'd2, "R4 count after ignored edge", int'(evt_count), 2);

            // R11 delay extremes
            hold_dly = 8'd0;
            fire(63, lat); tick();
            check(lat == 2, "R11 latency D=0", lat, 2);
            hold_dly = 8'd255;
            fire(0, lat); tick();
            check(lat == 257, "R11 latency D=255", lat, 257);

            // R2 level held high yields one event
            hold_dly = 8'd2;
            h0 = hold_seen;
            trig_ch[12] = 1'b1; tick(30); trig_ch = '0; tick(3);
            check(hold_seen - h0 == 1 && evt_count == 4'd5, "R2 level gives one event", int'(evt_count), 5);

            // R7 fill the store
            hold_dly = 8'd1;
            while (evt_count < 4'd15 && !chip_sat) begin fire(20, lat); tick(); end
            check(chip_sat == 1'b1 && evt_count == 4'd15 && cell_sel == '0, "R7 full sets sat",
                  int'({chip_sat, evt_count}), 31);
            h0 = hold_seen;
            trig_ch[3] = 1'b1; tick(); trig_ch = '0; tick(8);
            check(hold_seen == h0, "R7 no strobe when saturated", hold_seen - h0, 0);

            // R10 start together with a trigger edge
            acq_start = 1'b1; trig_ch[9] = 1'b1; tick(); acq_start = 1'b0; tick(10);
            check(evt_count == '0 && chip_sat == 1'b0 && cell_sel == 15'd1, "R10 start clears",
                  int'(evt_count), 0);
            check(hold_seen == h0, "R10 same-cycle trigger ignored", hold_seen - h0, 0);
            trig_ch = '0; tick();

            // R8 stop during a pending delay
            hold_dly = 8'd50;
            h0 = hold_seen;
            trig_ch[33] = 1'b1; tick(); trig_ch = '0; tick(10);
            acq_stop = 1'b1; tick(); acq_stop = 1'b0;
            check(chip_sat == 1'b1, "R8 stop sets sat", int'(chip_sat), 1);
            tick(60);
            check(hold_seen == h0 && evt_count == '0, "R8 pending hold dropped", hold_seen - h0, 0);

            // R9 stop in the strobe cycle
            pulse_start();
            hold_dly = 8'd2;
            trig_ch[2] = 1'b1; tick(); trig_ch = '0;
            while (!hold_strobe) tick();
            acq_stop = 1'b1; tick(); acq_stop = 1'b0;
            check(evt_count == 4'd1 && chip_sat == 1'b1, "R9 stop with strobe counts",
                  int'({chip_sat, evt_count}), 17);
        end

        // random phase, judged cycle by cycle by the model
        pulse_start();
        for (int c = 0; c < 6000; c++) begin
            trig_ch = ($urandom % 12 == 0) ? (64'd1 << ($urandom % N_CH)) : '0;
            if (c % 97 == 0) hold_dly = DLY_W'($urandom % 12);
            acq_stop  = ($urandom % 350 == 0);
            acq_start = (chip_sat && $urandom % 15 == 0) || ($urandom % 500 == 0);
            tick();
        end
        acq_start = 1'b0; acq_stop = 1'b0; trig_ch = '0;
        tick(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule